// File: doc/BRIEF.md
# Bus Clock Divider Ratio Selector

This block works out the divider settings for a clock tree from four frequencies, all given as unsigned integers in Hz. The inputs are the core clock, the wanted processor clock, and the highest bus clock and highest peripheral clock allowed. A one-cycle start strobe captures the inputs. The block then searches the allowed bus divisors, computing each candidate bus frequency with a sequential restoring divider. When the search ends it reports five results:

- the chosen bus divisor;
- the total peripheral divisor, counted from the core clock;
- a voltage-scaling flag, set when the processor clock is tied to the bus clock;
- the processor clock frequency after the rules below are applied;
- a valid status.

The results come with a one-cycle done pulse and are held until the next search finishes. Software or a power controller uses them when it changes clock rates. The block does not write divider registers itself.

Top module: `clk_ratio_sel`

## Requirements
- R1: The divisors allowed for the bus clock are 1, 2, 3, 4, 6 and 8, tried smallest first. The first one that meets the limit is chosen. `hdiv_o` gives the chosen divisor as a plain binary integer.
- R2: A candidate divisor d is accepted when core/d (the integer quotient) is at most the bus limit plus 1000 Hz. This covers both results at or below the limit and results up to 1000 Hz above it.
- R3: A requested processor clock above the core clock is treated as equal to the core clock.
- R4: When the processor clock (after R3) is below both the core clock and the bus maximum, the processor clock is used as the bus limit instead of the bus maximum.
- R5: The peripheral factor is 1 when the bus clock is at or below the peripheral maximum, and 2 otherwise. If the factor is 2 and bus/2 is still above the peripheral maximum, the result is invalid. `pdiv_o` equals the factor times the bus divisor.
- R6: A processor clock below the bus clock is raised to the bus clock. If the result is still below the core clock, `dvs_o` is 1 and `arm_hz_o` equals the bus clock. Otherwise `dvs_o` is 0 and `arm_hz_o` equals the processor clock.
- R7: When no allowed divisor meets the limit, or R5 makes the result invalid, `valid_o` is 0 and `hdiv_o`, `pdiv_o`, `dvs_o` and `arm_hz_o` are all 0.
- R8: `busy_o` is high from the cycle after an accepted start until the result is returned. `done_o` is high for exactly one cycle, with `busy_o` low in that cycle. A start while busy is ignored.
- R9: The result outputs change only in the cycle where `done_o` is high. They hold their values until the next done pulse.
- R10: From the accepted start to the done pulse takes at most 6*(32+2)+2 = 206 clock cycles.
- R11: Reset, even during a search, clears busy, done, valid and all result outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a search; ignored while busy |
| core_hz_i | input | 32 | Core clock frequency, Hz |
| arm_hz_i | input | 32 | Requested processor clock, Hz |
| bus_max_i | input | 32 | Highest allowed bus clock, Hz |
| per_max_i | input | 32 | Highest allowed peripheral clock, Hz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| valid_o | output | 1 | The result is usable |
| hdiv_o | output | 4 | Bus divisor |
| pdiv_o | output | 5 | Total peripheral divisor, from the core clock |
| dvs_o | output | 1 | Processor clock tied to the bus clock |
| arm_hz_o | output | 32 | Processor clock after adjustment, Hz |

## Verification
A wrong quotient or an off-by-one step count in the divider picks the wrong divisor. That shows at the done pulse as a wrong `hdiv_o` and a wrong `pdiv_o`, or as a false invalid. The bench therefore places inputs at a candidate boundary, right at the edge of the 1000 Hz tolerance and just beyond it. A stuck state in the candidate walk shows as `busy_o` staying high past the 206-cycle limit. A missing clamp or a missing lowering of the limit shows as a wrong `dvs_o` or a wrong `arm_hz_o`, one cycle after the search ends.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int N_CAND = 6;
  localparam int IDX_W  = $clog2(N_CAND);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT,
    ST_FINISH
  } sel_st_e;

  // allowed bus divisors, ascending; 5 and 7 are not allowed
  function automatic logic [3:0] cand_div(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    cand_div = 4'd1;
      3'd1:    cand_div = 4'd2;
      3'd2:    cand_div = 4'd3;
      3'd3:    cand_div = 4'd4;
      3'd4:    cand_div = 4'd6;
      default: cand_div = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/clkdiv_seq_div.sv
module clkdiv_seq_div #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);

  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam int REM_W = DEN_W + 1;
  localparam int PW    = NUM_W + DEN_W + 1;

  logic [NUM_W-1:0] quo_q, num_q;
  logic [DEN_W-1:0] den_q;
  logic [REM_W-1:0] rem_q, rem_sh, rem_nx;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q, ge;

  always_comb begin
    rem_sh = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
    ge     = rem_sh >= {1'b0, den_q};
    rem_nx = ge ? rem_sh - {1'b0, den_q} : rem_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      num_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      quo_q  <= num_i;
      num_q  <= num_i;
      den_q  <= den_i;
      rem_q  <= '0;
      cnt_q  <= CNT_W'(NUM_W);
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (run_q) begin
      quo_q <= {quo_q[NUM_W-2:0], ge};
      rem_q <= rem_nx;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  logic [PW-1:0] chk_sum;
  always_comb chk_sum = PW'(quo_q) * PW'(den_q) + PW'(rem_q);

  AST_DIV_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (chk_sum == PW'(num_q)) && (rem_q < {1'b0, den_q})) else $error("div"); // R2

endmodule

// File: rtl/clkdiv_post.sv
module clkdiv_post #(
  parameter int FREQ_W = 32,
  parameter int DIV_W  = 4
) (
  input  logic              found_i,
  input  logic [FREQ_W-1:0] core_i,
  input  logic [FREQ_W-1:0] arm_i,
  input  logic [FREQ_W-1:0] bus_i,
  input  logic [FREQ_W-1:0] per_max_i,
  input  logic [DIV_W-1:0]  hdiv_i,
  output logic              ok_o,
  output logic [DIV_W-1:0]  hdiv_o,
  output logic [DIV_W:0]    pdiv_o,
  output logic              dvs_o,
  output logic [FREQ_W-1:0] arm_o
);

  logic              per_x2, per_bad, dvs;
  logic [FREQ_W-1:0] arm_up;

  always_comb begin
    per_x2  = bus_i > per_max_i;
    per_bad = per_x2 && ((bus_i >> 1) > per_max_i);
    arm_up  = (arm_i < bus_i) ? bus_i : arm_i;
    dvs     = arm_up < core_i;
    ok_o    = found_i && !per_bad;
    if (ok_o) begin
      hdiv_o = hdiv_i;
      pdiv_o = per_x2 ? {hdiv_i, 1'b0} : {1'b0, hdiv_i};
      dvs_o  = dvs;
      arm_o  = dvs ? bus_i : arm_up;
    end else begin
      hdiv_o = '0;
      pdiv_o = '0;
      dvs_o  = 1'b0;
      arm_o  = '0;
    end
  end

endmodule

// File: rtl/clk_ratio_sel.sv
module clk_ratio_sel
  import clkdiv_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int DIV_W  = 4,
  parameter int TOL_HZ = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] core_hz_i,
  input  logic [FREQ_W-1:0] arm_hz_i,
  input  logic [FREQ_W-1:0] bus_max_i,
  input  logic [FREQ_W-1:0] per_max_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              valid_o,
  output logic [DIV_W-1:0]  hdiv_o,
  output logic [DIV_W:0]    pdiv_o,
  output logic              dvs_o,
  output logic [FREQ_W-1:0] arm_hz_o
);

  localparam int MAX_LAT = N_CAND * (FREQ_W + 2) + 2;
  localparam int LAT_W   = $clog2(MAX_LAT + 1) + 1;

  sel_st_e           state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [FREQ_W-1:0] core_q, arm_q, lim_q, per_q, bus_q;
  logic [DIV_W-1:0]  hdiv_q;
  logic              found_q;

  logic              div_go, div_done;
  logic [FREQ_W-1:0] div_quo;
  logic              accept;
  logic [FREQ_W-1:0] arm_clamp, lim_init;

  logic              p_ok, p_dvs;
  logic [DIV_W-1:0]  p_hdiv;
  logic [DIV_W:0]    p_pdiv;
  logic [FREQ_W-1:0] p_arm;

  assign div_go = (state_q == ST_LAUNCH);
  assign busy_o = (state_q != ST_IDLE);

  always_comb begin
    arm_clamp = (arm_hz_i > core_hz_i) ? core_hz_i : arm_hz_i;
    lim_init  = (arm_clamp < core_hz_i && arm_clamp < bus_max_i) ? arm_clamp : bus_max_i;
    accept    = {1'b0, div_quo} <= ({1'b0, lim_q} + (FREQ_W+1)'(TOL_HZ));
  end

  clkdiv_seq_div #(.NUM_W(FREQ_W), .DEN_W(DIV_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_go),
    .num_i   (core_q),
    .den_i   (cand_div(idx_q)),
    .done_o  (div_done),
    .quo_o   (div_quo)
  );

  clkdiv_post #(.FREQ_W(FREQ_W), .DIV_W(DIV_W)) u_post (
    .found_i   (found_q),
    .core_i    (core_q),
    .arm_i     (arm_q),
    .bus_i     (bus_q),
    .per_max_i (per_q),
    .hdiv_i    (hdiv_q),
    .ok_o      (p_ok),
    .hdiv_o    (p_hdiv),
    .pdiv_o    (p_pdiv),
    .dvs_o     (p_dvs),
    .arm_o     (p_arm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      core_q   <= '0;
      arm_q    <= '0;
      lim_q    <= '0;
      per_q    <= '0;
      bus_q    <= '0;
      hdiv_q   <= '0;
      found_q  <= 1'b0;
      done_o   <= 1'b0;
      valid_o  <= 1'b0;
      hdiv_o   <= '0;
      pdiv_o   <= '0;
      dvs_o    <= 1'b0;
      arm_hz_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          core_q  <= core_hz_i;
          arm_q   <= arm_clamp;
          lim_q   <= lim_init;
          per_q   <= per_max_i;
          idx_q   <= '0;
          found_q <= 1'b0;
          state_q <= ST_LAUNCH;
        end
        ST_LAUNCH: state_q <= ST_WAIT;
        ST_WAIT: if (div_done) begin
          if (accept) begin
            bus_q   <= div_quo;
            hdiv_q  <= cand_div(idx_q);
            found_q <= 1'b1;
            state_q <= ST_FINISH;
          end else if (idx_q == IDX_W'(N_CAND - 1)) begin
            state_q <= ST_FINISH;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_LAUNCH;
          end
        end
        default: begin
          valid_o  <= p_ok;
          hdiv_o   <= p_hdiv;
          pdiv_o   <= p_pdiv;
          dvs_o    <= p_dvs;
          arm_hz_o <= p_arm;
          done_o   <= 1'b1;
          state_q  <= ST_IDLE;
        end
      endcase
    end
  end

  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lat_q <= '0;
    else if (busy_o) lat_q <= lat_q + 1'b1;
    else             lat_q <= '0;
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_q <= LAT_W'(MAX_LAT)) else $error("lat"); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("pulse"); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o) else $error("idle"); // R8
  AST_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({valid_o, hdiv_o, pdiv_o, dvs_o, arm_hz_o})) else $error("held"); // R9
  AST_HDIV_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (hdiv_o inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8})) else $error("hdiv"); // R1
  AST_PDIV_MULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (pdiv_o == {1'b0, hdiv_o} || pdiv_o == {hdiv_o, 1'b0})) else $error("pdiv"); // R5
  AST_INVALID_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (hdiv_o == '0 && pdiv_o == '0 && !dvs_o && arm_hz_o == '0)) else $error("zero"); // R7

endmodule

// File: tb/clk_ratio_sel_tb_top.sv
`timescale 1ns/1ps
module clk_ratio_sel_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] core_hz_i = '0, arm_hz_i = '0, bus_max_i = '0, per_max_i = '0;
  logic        busy_o, done_o, valid_o, dvs_o;
  logic [3:0]  hdiv_o;
  logic [4:0]  pdiv_o;
  logic [31:0] arm_hz_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  clk_ratio_sel dut_i (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // independent reference of the requirements
  task automatic model(input longint core, input longint arm, input longint bmax,
                       input longint pmax, output bit ok, output int hd, output int pd,
                       output bit dv, output longint ao);
    int dl[6] = '{1, 2, 3, 4, 6, 8};
    longint a = (arm > core) ? core : arm;                  // R3
    longint lim = (a < core && a < bmax) ? a : bmax;        // R4
    longint bus = 0;
    int sub;
    ok = 0; hd = 0; pd = 0; dv = 0; ao = 0;
    for (int i = 0; i < 6; i++) begin
      if (core / dl[i] <= lim + 1000) begin                  // R1 R2
        hd = dl[i]; bus = core / dl[i]; ok = 1;
        break;
      end
    end
    if (!ok) begin hd = 0; return; end
    sub = (bus > pmax) ? 2 : 1;
    if (bus / sub > pmax) begin ok = 0; hd = 0; return; end  // R5
    pd = sub * hd;
    if (a < bus) a = bus;                                    // R6
    dv = (a < core);
    ao = dv ? bus : a;
  endtask

  task automatic run_case(input string name, input longint core, input longint arm,
                          input longint bmax, input longint pmax);
    bit ok, dv; int hd, pd; longint ao; int cyc;
    model(core, arm, bmax, pmax, ok, hd, pd, dv, ao);
    @(negedge clk_i);
    core_hz_i = 32'(core); arm_hz_i = 32'(arm); bus_max_i = 32'(bmax); per_max_i = 32'(pmax);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
    cyc = 1;
    while (!done_o && cyc < 400) begin @(negedge clk_i); cyc++; end
    chk(cyc <= 206, "R10 latency", cyc, 206);
    chk(done_o && !busy_o, "R8 done without busy", busy_o, 0);
    $display("case %s", name);
    chk(valid_o == ok, "R7 valid", valid_o, ok);
    chk(hdiv_o == hd, "R1 hdiv", hdiv_o, hd);
    chk(pdiv_o == pd, "R5 pdiv", pdiv_o, pd);
    chk(dvs_o == dv, "R6 dvs", dvs_o, dv);
    chk(arm_hz_o == ao, "R6 arm", arm_hz_o, ao);
    @(negedge clk_i);
    chk(!done_o, "R8 done one cycle", done_o, 0);
  endtask

  task automatic exp_case(input string req, input longint core, input longint arm,
                          input longint bmax, input longint pmax,
                          input bit ok, input int hd, input int pd, input bit dv, input longint ao);
    run_case(req, core, arm, bmax, pmax);
    chk(valid_o == ok && hdiv_o == hd && pdiv_o == pd && dvs_o == dv && arm_hz_o == ao,
        req, {valid_o, hdiv_o, pdiv_o, dvs_o}, {ok, 4'(hd), 5'(pd), dv});
  endtask

  task automatic t_hold();
    logic [42:0] snap = {valid_o, hdiv_o, pdiv_o, dvs_o, arm_hz_o};
    core_hz_i = 32'd7; arm_hz_i = 32'd1; bus_max_i = 32'd1; per_max_i = 32'd1;
    repeat (8) @(negedge clk_i);
    chk({valid_o, hdiv_o, pdiv_o, dvs_o, arm_hz_o} == snap, "R9 held", arm_hz_o, snap[31:0]);
  endtask

  task automatic t_start_busy();
    // second start while busy must be ignored
    @(negedge clk_i);
    core_hz_i = 400_000_000; arm_hz_i = 400_000_000; bus_max_i = 133_333_333; per_max_i = 66_666_666;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (10) @(negedge clk_i);
    core_hz_i = 100_000_000; arm_hz_i = 100_000_000; bus_max_i = 100_000_000; per_max_i = 100_000_000;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done_o) @(negedge clk_i);
    chk(hdiv_o == 3 && pdiv_o == 6, "R8 start ignored while busy", hdiv_o, 3);
    @(negedge clk_i);
    chk(!busy_o, "R8 no extra run", busy_o, 0);
  endtask

  task automatic t_reset_mid();
    @(negedge clk_i);
    core_hz_i = 300_000_000; arm_hz_i = 300_000_000; bus_max_i = 50_000_000; per_max_i = 50_000_000;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (20) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !valid_o && hdiv_o == 0 && arm_hz_o == 0, "R11 reset mid search",
        busy_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_random();
    int unsigned s = 32'h1234_5678;
    for (int i = 0; i < 25; i++) begin
      longint c, a, b, p;
      s = s * 1664525 + 1013904223; c = 1_000_000 + (s % 400_000_000);
      s = s * 1664525 + 1013904223; a = s % 500_000_000;
      s = s * 1664525 + 1013904223; b = 1 + (s % 200_000_000);
      s = s * 1664525 + 1013904223; p = 1 + (s % 100_000_000);
      run_case("R1 R5 R6 random", c, a, b, p);
    end
  endtask

  initial begin : watchdog
    repeat (150_000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !valid_o && hdiv_o == 0 && pdiv_o == 0 && !dvs_o && arm_hz_o == 0,
        "R11 reset state", valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    exp_case("R1 R5 nominal", 400_000_000, 400_000_000, 133_333_333, 66_666_666, 1, 3, 6, 0, 400_000_000);
    t_hold();
    exp_case("R2 within tolerance", 400_000_000, 400_000_000, 133_332_500, 66_666_666, 1, 3, 6, 0, 400_000_000);
    exp_case("R2 outside tolerance", 400_000_000, 400_000_000, 133_332_000, 66_666_666, 1, 4, 8, 0, 400_000_000);
    exp_case("R3 clamp", 400_000_000, 500_000_000, 133_333_333, 66_666_666, 1, 3, 6, 0, 400_000_000);
    exp_case("R4 R6 dvs", 400_000_000, 100_000_000, 133_333_333, 66_666_666, 1, 4, 8, 1, 100_000_000);
    exp_case("R6 arm raised", 400_000_000, 140_000_000, 133_333_333, 66_666_666, 1, 3, 6, 1, 133_333_333);
    exp_case("R7 no divisor", 400_000_000, 400_000_000, 40_000_000, 40_000_000, 0, 0, 0, 0, 0);
    exp_case("R5 R7 per too fast", 400_000_000, 400_000_000, 200_000_000, 50_000_000, 0, 0, 0, 0, 0);
    exp_case("R5 factor one", 100_000_000, 100_000_000, 100_000_000, 100_000_000, 1, 1, 1, 0, 100_000_000);
    exp_case("R1 divisor six", 300_000_000, 300_000_000, 50_000_000, 50_000_000, 1, 6, 6, 0, 300_000_000);
    exp_case("R1 R10 divisor eight", 400_000_000, 400_000_000, 50_000_000, 50_000_000, 1, 8, 8, 0, 400_000_000);
    t_start_busy();
    t_reset_mid();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule